// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block sits between a set of peripheral interrupt request lines and a CPU. Every source owns a 3-bit priority level, where a smaller number means more urgent and the value 7 switches that source off. Every clock the block looks at all asserted requests and picks one winner. The lowest level wins. When several requests share that lowest level, the lowest source index wins.

The winner's level is then compared with a programmable threshold level. The CPU request is raised only when the winner's level is strictly below the threshold and a global enable bit is set. The winner's index and level are presented on outputs together with a valid flag, so the CPU side can identify the cause.

Configuration is written through a simple write port made of an enable, an address and a data field. The arbitration result is registered once, so every output is a clean flop output.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset the outputs are irq_o=0, win_valid_o=0, win_idx_o=0 and win_lvl_o=7. Every source level resets to 7, the threshold resets to 0 and the enable bit resets to 0.
- R2: A source whose level is 7 never wins, even while its request is asserted.
- R3: Among asserted requests from enabled sources, the one with the numerically lowest level wins. win_idx_o and win_lvl_o report that winner.
- R4: When asserted requests tie at the lowest level, the source with the lowest index wins.
- R5: irq_o is 1 only when the winner's level is strictly less than the threshold. For example, a level-3 winner raises irq_o only for thresholds 4 through 7.
- R6: irq_o is 1 only while the enable bit is 1. Only bit 0 of wr_data_i is stored as the enable bit.
- R7: Outputs follow a change on req_i one clock edge later. A configuration write is stored at the edge where wr_en_i is sampled high, and its effect reaches the outputs at the following edge.
- R8: When no asserted request comes from an enabled source, win_valid_o=0, win_idx_o=0, win_lvl_o=7 and irq_o=0.
- R9: Write address k in 0..NUM_SRC-1 sets the level of source k. Address NUM_SRC sets the threshold. Address NUM_SRC+1 sets the enable bit. Writes to any higher address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Level-sensitive request per source, bit k is source k |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration write address |
| wr_data_i | input | 3 | Configuration write data |
| irq_o | output | 1 | Interrupt request to the CPU |
| win_valid_o | output | 1 | A qualifying winner exists |
| win_idx_o | output | IDX_W | Index of the winning source |
| win_lvl_o | output | 3 | Level of the winning source, 7 when none |

## Verification
A change on req_i shows up on the outputs exactly one rising edge later. A configuration write needs two edges: the edge that stores it and the edge that registers the new result. The bench drives every input on a falling edge and samples every output on a falling edge. The step count before each check follows these latencies. The latency test also samples once before the due edge, to confirm the old value is still held.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] level_t;

    // All-ones level switches a source off
    localparam level_t LVL_OFF = '1;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int ADDR_W  = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  level_t                           wr_data_i,
    output logic [NUM_SRC-1:0][LVL_W-1:0]    lvl_o,
    output level_t                           mask_o,
    output logic                             en_o
);

    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
        level_t                        mask;
        logic                          en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (wr_addr_i == ADDR_W'(k)) begin
                    cfg_d.lvl[k] = wr_data_i;
                end
            end
            if (wr_addr_i == MASK_ADDR) begin
                cfg_d.mask = wr_data_i;
            end
            if (wr_addr_i == EN_ADDR) begin
                cfg_d.en = wr_data_i[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                cfg_q.lvl[k] <= LVL_OFF;
            end
            cfg_q.mask <= '0;
            cfg_q.en   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lvl_o  = cfg_q.lvl;
    assign mask_o = cfg_q.mask;
    assign en_o   = cfg_q.en;

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]               req_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]    lvl_i,
    output logic                             valid_o,
    output logic [IDX_W-1:0]                 idx_o,
    output level_t                           lvl_o
);

    // Scan from index 0 upward; a later source replaces the running best
    // only with a strictly lower level, so ties keep the lower index.
    logic   [NUM_SRC:0] run_v;
    level_t             run_l [NUM_SRC+1];
    logic   [IDX_W-1:0] run_i [NUM_SRC+1];

    assign run_v[0] = 1'b0;
    assign run_l[0] = LVL_OFF;
    assign run_i[0] = '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_scan
        logic cand_ok;
        logic take;
        assign cand_ok = req_i[g] && (lvl_i[g] != LVL_OFF);
        assign take    = cand_ok && (!run_v[g] || (lvl_i[g] < run_l[g]));
        assign run_v[g+1] = run_v[g] | cand_ok;
        assign run_l[g+1] = take ? lvl_i[g] : run_l[g];
        assign run_i[g+1] = take ? IDX_W'(g) : run_i[g];
    end

    assign valid_o = run_v[NUM_SRC];
    assign idx_o   = run_i[NUM_SRC];
    assign lvl_o   = run_l[NUM_SRC];

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import prio_irq_pkg::*;
(
    input  logic   valid_i,
    input  level_t lvl_i,
    input  level_t mask_i,
    input  logic   en_i,
    output logic   accept_o
);

    assign accept_o = valid_i && en_i && (lvl_i < mask_i);

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int ADDR_W  = $clog2(NUM_SRC + 2),
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  req_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [LVL_W-1:0]    wr_data_i,
    output logic                irq_o,
    output logic                win_valid_o,
    output logic [IDX_W-1:0]    win_idx_o,
    output logic [LVL_W-1:0]    win_lvl_o
);

    typedef struct packed {
        logic             irq;
        logic             valid;
        logic [IDX_W-1:0] idx;
        level_t           lvl;
    } res_t;

    logic [NUM_SRC-1:0][LVL_W-1:0] cfg_lvl;
    level_t                        cfg_mask;
    logic                          cfg_en;

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    level_t           pick_lvl;
    logic             pick_accept;

    res_t res_d, res_q;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lvl_o     (cfg_lvl),
        .mask_o    (cfg_mask),
        .en_o      (cfg_en)
    );

    irq_level_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req_i   (req_i),
        .lvl_i   (cfg_lvl),
        .valid_o (pick_valid),
        .idx_o   (pick_idx),
        .lvl_o   (pick_lvl)
    );

    irq_accept u_acc (
        .valid_i  (pick_valid),
        .lvl_i    (pick_lvl),
        .mask_i   (cfg_mask),
        .en_i     (cfg_en),
        .accept_o (pick_accept)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = pick_valid;
        res_d.irq   = pick_accept;
        res_d.idx   = pick_valid ? pick_idx : '0;
        res_d.lvl   = pick_valid ? pick_lvl : LVL_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q.irq   <= 1'b0;
            res_q.valid <= 1'b0;
            res_q.idx   <= '0;
            res_q.lvl   <= LVL_OFF;
        end else begin
            res_q <= res_d;
        end
    end

    assign irq_o       = res_q.irq;
    assign win_valid_o = res_q.valid;
    assign win_idx_o   = res_q.idx;
    assign win_lvl_o   = res_q.lvl;

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input level_t             cfg_mask,
    input logic               cfg_en,
    input logic               irq_o,
    input logic               win_valid_o,
    input logic [IDX_W-1:0]   win_idx_o,
    input logic [LVL_W-1:0]   win_lvl_o
);

    logic [NUM_SRC-1:0] req_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_seen_q <= '0;
        else        req_seen_q <= req_i;
    end

    AST_OFF_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (win_lvl_o != LVL_OFF)); // R2

    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> req_seen_q[win_idx_o]); // R3

    AST_IRQ_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_valid_o && (win_lvl_o < $past(cfg_mask)))); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(cfg_en)); // R6

    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_o |-> (win_idx_o == '0 && win_lvl_o == LVL_OFF && !irq_o)); // R8

    AST_EMPTY_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_seen_q == '0) |-> !win_valid_o); // R7

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .cfg_mask    (cfg_mask),
    .cfg_en      (cfg_en),
    .irq_o       (irq_o),
    .win_valid_o (win_valid_o),
    .win_idx_o   (win_idx_o),
    .win_lvl_o   (win_lvl_o)
);

// File: tb/prio_irq_arbiter_test.sv
`timescale 1ns/1ps
module prio_irq_arbiter_test;

    localparam int N  = 5;
    localparam int AW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2:0]    wr_data = '0;
    logic          irq;
    logic          win_valid;
    logic [IW-1:0] win_idx;
    logic [2:0]    win_lvl;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_arbiter #(.NUM_SRC(N)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .irq_o       (irq),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        wr_en = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // One write; the storing edge passes before this task returns
    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = 3'(data);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int v, input int idx, input int lvl, input int q);
        chk({tag, " valid"}, 32'(win_valid), 32'(v));
        chk({tag, " idx"},   32'(win_idx),   32'(idx));
        chk({tag, " lvl"},   32'(win_lvl),   32'(lvl));
        chk({tag, " irq"},   32'(irq),       32'(q));
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset", 0, 0, 7, 0);
        req = '1;
        step(1);
        expect_out("R1 levels reset off", 0, 0, 7, 0);
        wr(N + 1, 1);
        wr(0, 2);
        step(1);
        expect_out("R1 mask reset zero", 1, 0, 2, 0);
    endtask

    task automatic t_lowest();
        do_reset();
        wr(0, 5); wr(1, 4); wr(2, 6); wr(3, 2); wr(4, 3);
        wr(N, 7); wr(N + 1, 1);
        req = 5'b11111;
        step(1);
        expect_out("R3 all req", 1, 3, 2, 1);
        req = 5'b10111;
        step(1);
        expect_out("R3 drop best", 1, 4, 3, 1);
        req = 5'b00101;
        step(1);
        expect_out("R3 pair", 1, 0, 5, 1);
    endtask

    task automatic t_tie();
        do_reset();
        wr(0, 7); wr(1, 3); wr(2, 3); wr(3, 3); wr(4, 3);
        wr(N, 4); wr(N + 1, 1);
        req = 5'b11111;
        step(1);
        expect_out("R4 tie low index", 1, 1, 3, 1);
        req = 5'b10100;
        step(1);
        expect_out("R4 tie pick 2", 1, 2, 3, 1);
    endtask

    task automatic t_disabled();
        do_reset();
        wr(2, 7); wr(4, 6); wr(N, 7); wr(N + 1, 1);
        req = 5'b00100;
        step(1);
        expect_out("R2 R8 only off src", 0, 0, 7, 0);
        req = 5'b10100;
        step(1);
        expect_out("R2 off src skipped", 1, 4, 6, 1);
        req = 5'b00000;
        step(1);
        expect_out("R8 no req", 0, 0, 7, 0);
    endtask

    task automatic t_mask();
        do_reset();
        wr(1, 3); wr(N + 1, 1);
        req = 5'b00010;
        for (int m = 0; m < 8; m++) begin
            wr(N, m);
            step(1);
            chk($sformatf("R5 mask=%0d irq", m), 32'(irq), (m > 3) ? 32'd1 : 32'd0);
            chk($sformatf("R5 mask=%0d valid", m), 32'(win_valid), 32'd1);
        end
    endtask

    task automatic t_enable();
        do_reset();
        wr(0, 1); wr(N, 7);
        req = 5'b00001;
        step(1);
        expect_out("R6 en off", 1, 0, 1, 0);
        wr(N + 1, 1);
        step(1);
        chk("R6 en on irq", 32'(irq), 32'd1);
        wr(N + 1, 6);
        step(1);
        chk("R6 bit0 only irq", 32'(irq), 32'd0);
    endtask

    task automatic t_latency();
        do_reset();
        wr(2, 1); wr(3, 4); wr(N, 5); wr(N + 1, 1);
        step(1);
        req = 5'b01100;
        #1;
        chk("R7 req not yet", 32'(win_valid), 32'd0);
        step(1);
        expect_out("R7 req one edge", 1, 2, 1, 1);
        wr(2, 6);
        chk("R7 write not yet idx", 32'(win_idx), 32'd2);
        step(1);
        expect_out("R7 write next edge", 1, 3, 4, 1);
    endtask

    task automatic t_addr();
        do_reset();
        wr(4, 2); wr(N, 7); wr(N + 1, 1);
        req = 5'b10000;
        step(1);
        expect_out("R9 base", 1, 4, 2, 1);
        wr(7, 0);
        step(1);
        expect_out("R9 high addr ignored", 1, 4, 2, 1);
        wr(N, 2);
        step(1);
        expect_out("R9 mask addr", 1, 4, 2, 0);
    endtask

    initial begin
        t_reset();
        t_lowest();
        t_tie();
        t_disabled();
        t_mask();
        t_enable();
        t_latency();
        t_addr();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule